// File: doc/BRIEF.md
# Power-up configuration loader for a four-lane redriver

This block brings a quad-lane redriver out of reset. While the reset input is high, it holds every lane in a fixed default configuration. When reset falls, a hold-off counter starts. The block stays busy until the count completes, and the serial management port is locked out while it is busy.

When the hold-off expires, the block samples the global control pins in a single cycle. It copies each pin's value into the matching field of every lane and hands the five control register images to the register file with a load strobe. The mode pin is captured at the same moment and selects how the block behaves from then on:

- **Serial mode:** the sampled values are only start-up defaults. Register writes belong to the serial port.
- **Pin mode:** the images keep tracking the pins every cycle. The serial port may only read, and its read view carries channel 0 fields alone.

Top module: `pwrup_cfg_loader`

## Requirements
- R1: While `rst` is high, `busy` is 1 and `load_stb` and `wr_allow` are 0. The reset images are:
  - `cfg_pe` and `cfg_lvl`: all zero.
  - `cfg_onpol`: output-on bits (upper NCH bits) all 1, polarity bits (lower NCH bits) 0.
  - `cfg_detmode`: all zero.
  - `cfg_ofsthr`: offset bits (upper) 0, threshold bits (lower) all 1.
- R2: After `rst` falls, `busy` stays 1 through the first HOLD_CYC-1 rising edges and falls on edge HOLD_CYC.
- R3: On the edge where `busy` falls, the pins are sampled into all five images and `load_stb` is 1 in that cycle.
- R4: If `rst` is raised during the hold-off, the count restarts from zero once it falls again.
- R5: When the mode pin was 1 at the sample edge (serial mode), the following apply:
  - `load_stb` is high for exactly one cycle.
  - The images ignore later pin changes.
  - `wr_allow` is 1.
- R6: When the mode pin was 0 at the sample edge (pin mode), the following apply:
  - The images follow the pins with one cycle of lag.
  - `load_stb` stays 1.
  - `wr_allow` is 0.
- R7: Field layout for lane n:
  - `cfg_pe[2n+1:2n]` and `cfg_lvl[2n+1:2n]` hold the preemphasis and level pins.
  - `cfg_onpol`: bit NCH+n is the output-enable pin; bit n is 0.
  - `cfg_detmode`: bit NCH+n is the squelch-enable pin; bit n is the fast-detect pin.
  - `cfg_ofsthr`: bit NCH+n is the offset-cancel pin; bit n is 1 whatever the pins.
- R8: In pin mode, the `rb_*` outputs are filtered:
  - `rb_pe` and `rb_lvl` keep only bits [1:0].
  - The other three keep only bits NCH and 0.
  - All other bits read 0.
  - Otherwise `rb_*` equal the `cfg_*` images.
- R9: The mode is latched only at the sample edge. A later change on `pin_i2c_mode` has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset, also models power-on |
| pin_tx_on | input | 1 | Global output-enable pin |
| pin_lvl | input | 2 | Global drive-level pins |
| pin_pe | input | 2 | Global preemphasis pins |
| pin_fast_det | input | 1 | Signal-detect speed select (1 = fast) |
| pin_sq_en | input | 1 | Squelch enable pin |
| pin_ofs_en | input | 1 | Offset-cancellation enable pin |
| pin_i2c_mode | input | 1 | 1 = serial programming, 0 = pin control |
| busy | output | 1 | Hold-off in progress; serial port must not respond |
| load_stb | output | 1 | Images are to be written into the register file |
| wr_allow | output | 1 | Serial writes permitted |
| cfg_pe | output | 2*NCH | Preemphasis image |
| cfg_lvl | output | 2*NCH | Drive-level image |
| cfg_onpol | output | 2*NCH | Output-on and polarity image |
| cfg_detmode | output | 2*NCH | Squelch and detect-speed image |
| cfg_ofsthr | output | 2*NCH | Offset-cancel and threshold image |
| rb_pe | output | 2*NCH | Read-back view of preemphasis image |
| rb_lvl | output | 2*NCH | Read-back view of level image |
| rb_onpol | output | 2*NCH | Read-back view of on/polarity image |
| rb_detmode | output | 2*NCH | Read-back view of detect-mode image |
| rb_ofsthr | output | 2*NCH | Read-back view of offset/threshold image |

## Verification
The bench builds the block with HOLD_CYC = 20 and NCH = 4. The short hold-off puts the exact falling edge of `busy` within a few dozen cycles, as well as a reset pulse in mid-count and a full second start-up in the other mode. With four lanes, every image is one byte, so the replicated fields and the read-back masks can be checked against hand-computed byte values.

// File: rtl/pwrup_cfg_loader.sv
module pwrup_cfg_loader #(
  parameter int NCH      = 4,
  parameter int HOLD_CYC = 25_000_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_tx_on,
  input  logic [1:0]       pin_lvl,
  input  logic [1:0]       pin_pe,
  input  logic             pin_fast_det,
  input  logic             pin_sq_en,
  input  logic             pin_ofs_en,
  input  logic             pin_i2c_mode,
  output logic             busy,
  output logic             load_stb,
  output logic             wr_allow,
  output logic [2*NCH-1:0] cfg_pe,
  output logic [2*NCH-1:0] cfg_lvl,
  output logic [2*NCH-1:0] cfg_onpol,
  output logic [2*NCH-1:0] cfg_detmode,
  output logic [2*NCH-1:0] cfg_ofsthr,
  output logic [2*NCH-1:0] rb_pe,
  output logic [2*NCH-1:0] rb_lvl,
  output logic [2*NCH-1:0] rb_onpol,
  output logic [2*NCH-1:0] rb_detmode,
  output logic [2*NCH-1:0] rb_ofsthr
);
  localparam int FW = 2*NCH;
  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC-1);
  localparam logic [FW-1:0] RST_ONPOL = {{NCH{1'b1}}, {NCH{1'b0}}};
  localparam logic [FW-1:0] RST_OFSTHR = {{NCH{1'b0}}, {NCH{1'b1}}};
  localparam logic [FW-1:0] MASK_PAIR = FW'(3);
  localparam logic [FW-1:0] MASK_SPLIT = FW'(1) | (FW'(1) << NCH);

  logic [CW-1:0] cnt;
  logic          i2c_q;
  logic [FW-1:0] pv_pe, pv_lvl, pv_onpol, pv_detmode, pv_ofsthr;

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign pv_pe[2*g +: 2]     = pin_pe;
    assign pv_lvl[2*g +: 2]    = pin_lvl;
    assign pv_onpol[NCH+g]     = pin_tx_on;
    assign pv_onpol[g]         = 1'b0;
    assign pv_detmode[NCH+g]   = pin_sq_en;
    assign pv_detmode[g]       = pin_fast_det;
    assign pv_ofsthr[NCH+g]    = pin_ofs_en;
    assign pv_ofsthr[g]        = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b1;
      cnt         <= '0;
      load_stb    <= 1'b0;
      i2c_q       <= 1'b0;
      cfg_pe      <= '0;
      cfg_lvl     <= '0;
      cfg_onpol   <= RST_ONPOL;
      cfg_detmode <= '0;
      cfg_ofsthr  <= RST_OFSTHR;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy        <= 1'b0;
        load_stb    <= 1'b1;
        i2c_q       <= pin_i2c_mode;
        cfg_pe      <= pv_pe;
        cfg_lvl     <= pv_lvl;
        cfg_onpol   <= pv_onpol;
        cfg_detmode <= pv_detmode;
        cfg_ofsthr  <= pv_ofsthr;
      end else begin
        cnt      <= cnt + 1'b1;
        load_stb <= 1'b0;
      end
    end else if (!i2c_q) begin
      load_stb    <= 1'b1;
      cfg_pe      <= pv_pe;
      cfg_lvl     <= pv_lvl;
      cfg_onpol   <= pv_onpol;
      cfg_detmode <= pv_detmode;
      cfg_ofsthr  <= pv_ofsthr;
    end else begin
      load_stb <= 1'b0;
    end
  end

  wire pin_ctl = !busy && !i2c_q;
  assign wr_allow   = !busy && i2c_q;
  assign rb_pe      = pin_ctl ? (cfg_pe      & MASK_PAIR)  : cfg_pe;
  assign rb_lvl     = pin_ctl ? (cfg_lvl     & MASK_PAIR)  : cfg_lvl;
  assign rb_onpol   = pin_ctl ? (cfg_onpol   & MASK_SPLIT) : cfg_onpol;
  assign rb_detmode = pin_ctl ? (cfg_detmode & MASK_SPLIT) : cfg_detmode;
  assign rb_ofsthr  = pin_ctl ? (cfg_ofsthr  & MASK_SPLIT) : cfg_ofsthr;

  a_r1_reset_holds: assert property (@(posedge clk)
    rst |=> (busy && !load_stb && cfg_pe == '0 && cfg_onpol == RST_ONPOL));

  a_r2_busy_until_count: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST) |=> busy);

  a_r3_load_on_release: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> load_stb);

  a_r5_serial_images_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_allow && $past(wr_allow)) |-> ($stable(cfg_pe) && $stable(cfg_onpol) && !load_stb));

  a_r6_pin_mode_tracks: assert property (@(posedge clk) disable iff (rst)
    (pin_ctl && $past(pin_ctl)) |-> (cfg_lvl == {NCH{$past(pin_lvl)}} && load_stb));
endmodule

// File: tb/pwrup_cfg_loader_tb.sv
module pwrup_cfg_loader_tb;
  localparam int NCH = 4;
  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin_tx_on = 1'b0, pin_fast_det = 1'b0, pin_sq_en = 1'b0, pin_ofs_en = 1'b0;
  logic pin_i2c_mode = 1'b0;
  logic [1:0] pin_lvl = '0, pin_pe = '0;
  logic busy, load_stb, wr_allow;
  logic [7:0] cfg_pe, cfg_lvl, cfg_onpol, cfg_detmode, cfg_ofsthr;
  logic [7:0] rb_pe, rb_lvl, rb_onpol, rb_detmode, rb_ofsthr;

  always #2 clk = ~clk;

  pwrup_cfg_loader #(.NCH(NCH), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst(rst), .pin_tx_on(pin_tx_on), .pin_lvl(pin_lvl), .pin_pe(pin_pe),
    .pin_fast_det(pin_fast_det), .pin_sq_en(pin_sq_en), .pin_ofs_en(pin_ofs_en),
    .pin_i2c_mode(pin_i2c_mode), .busy(busy), .load_stb(load_stb), .wr_allow(wr_allow),
    .cfg_pe(cfg_pe), .cfg_lvl(cfg_lvl), .cfg_onpol(cfg_onpol), .cfg_detmode(cfg_detmode),
    .cfg_ofsthr(cfg_ofsthr), .rb_pe(rb_pe), .rb_lvl(rb_lvl), .rb_onpol(rb_onpol),
    .rb_detmode(rb_detmode), .rb_ofsthr(rb_ofsthr));

  typedef struct {
    int         id;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  function automatic logic [7:0] sel(int id);
    case (id)
      0: return {7'd0, busy};
      1: return {7'd0, load_stb};
      2: return {7'd0, wr_allow};
      3: return cfg_pe;
      4: return cfg_lvl;
      5: return cfg_onpol;
      6: return cfg_detmode;
      7: return cfg_ofsthr;
      8: return rb_pe;
      9: return rb_lvl;
      10: return rb_onpol;
      11: return rb_detmode;
      default: return rb_ofsthr;
    endcase
  endfunction

  task automatic push(int id, logic [7:0] exp, string req);
    item_t it;
    it.id = id; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic push_ctl(logic b, logic l, logic w, string req);
    push(0, {7'd0, b}, req); push(1, {7'd0, l}, req); push(2, {7'd0, w}, req);
  endtask

  task automatic push_cfg(logic [7:0] pe, logic [7:0] lv, logic [7:0] op,
                          logic [7:0] dm, logic [7:0] ot, string req);
    push(3, pe, req); push(4, lv, req); push(5, op, req); push(6, dm, req); push(7, ot, req);
  endtask

  task automatic push_rb(logic [7:0] pe, logic [7:0] lv, logic [7:0] op,
                         logic [7:0] dm, logic [7:0] ot, string req);
    push(8, pe, req); push(9, lv, req); push(10, op, req); push(11, dm, req); push(12, ot, req);
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = sel(it.id);
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s: signal %0d actual %h expected %h", it.req, it.id, act, it.exp);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    pin_i2c_mode = 1'b1; pin_tx_on = 1'b1; pin_lvl = 2'b10; pin_pe = 2'b01;
    pin_fast_det = 1'b1; pin_sq_en = 1'b0; pin_ofs_en = 1'b1;
    edges(3);
    // R1 reset state, read-back equals images while busy (R8)
    push_ctl(1'b1, 1'b0, 1'b0, "R1");
    push_cfg(8'h00, 8'h00, 8'hF0, 8'h00, 8'h0F, "R1");
    push_rb(8'h00, 8'h00, 8'hF0, 8'h00, 8'h0F, "R8");
    @(negedge clk) rst = 1'b0;
    edges(10);
    push_ctl(1'b1, 1'b0, 1'b0, "R2");
    @(negedge clk) rst = 1'b1;
    edges(2);
    @(negedge clk) rst = 1'b0;
    // R4 restart: busy still high after HOLD-1 edges from the second release
    edges(HOLD - 1);
    push_ctl(1'b1, 1'b0, 1'b0, "R4");
    edges(1);
    // R2 busy falls, R3 load, R7 layout, R5 serial mode
    push_ctl(1'b0, 1'b1, 1'b1, "R3");
    push_cfg(8'h55, 8'hAA, 8'hF0, 8'h0F, 8'hFF, "R7");
    push_rb(8'h55, 8'hAA, 8'hF0, 8'h0F, 8'hFF, "R8");
    edges(1);
    push_ctl(1'b0, 1'b0, 1'b1, "R5");
    @(negedge clk);
    pin_pe = 2'b11; pin_tx_on = 1'b0; pin_i2c_mode = 1'b0;
    edges(3);
    // R5 images ignore pins; R9 mode change has no effect
    push_cfg(8'h55, 8'hAA, 8'hF0, 8'h0F, 8'hFF, "R5");
    push_ctl(1'b0, 1'b0, 1'b1, "R9");
    push_rb(8'h55, 8'hAA, 8'hF0, 8'h0F, 8'hFF, "R9");

    @(negedge clk);
    rst = 1'b1;
    pin_tx_on = 1'b0; pin_lvl = 2'b01; pin_pe = 2'b10;
    pin_fast_det = 1'b0; pin_sq_en = 1'b1; pin_ofs_en = 1'b0;
    edges(2);
    push_cfg(8'h00, 8'h00, 8'hF0, 8'h00, 8'h0F, "R1");
    push_ctl(1'b1, 1'b0, 1'b0, "R1");
    @(negedge clk) rst = 1'b0;
    edges(HOLD);
    // pin mode start-up: R3, R6, R7, R8
    push_ctl(1'b0, 1'b1, 1'b0, "R6");
    push_cfg(8'hAA, 8'h55, 8'h00, 8'hF0, 8'h0F, "R7");
    push_rb(8'h02, 8'h01, 8'h00, 8'h10, 8'h01, "R8");
    @(negedge clk);
    pin_pe = 2'b11; pin_lvl = 2'b00; pin_tx_on = 1'b1; pin_fast_det = 1'b1;
    edges(1);
    push_cfg(8'hFF, 8'h00, 8'hF0, 8'hFF, 8'h0F, "R6");
    push_rb(8'h03, 8'h00, 8'h10, 8'h11, 8'h01, "R8");
    push_ctl(1'b0, 1'b1, 1'b0, "R6");
    @(negedge clk);
    pin_ofs_en = 1'b1; pin_sq_en = 1'b0;
    edges(1);
    push(6, 8'h0F, "R6"); push(7, 8'hFF, "R7"); push(12, 8'h11, "R8");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule